// File: doc/BRIEF.md
# Two-Thread Decode Slot Arbiter with Congestion Throttling

The arbiter sits in front of a shared decode stage and picks, every clock cycle, which of two hardware threads may use the decode slot. Software gives each thread a 3-bit priority. Level 0 parks a thread. Levels 1 to 7 rank the running threads, with 7 the most favoured. A running thread with the higher priority gets a larger share of decode cycles. The share grows with the priority gap, and equal priorities share the slot half and half. When both threads sit at level 1 the arbiter drops into a power-saving cadence and hands out only one decode cycle per `PSAVE_PERIOD` cycles.

Per-thread congestion monitors can take cycles away from a thread. A thread holding too many completion-table entries competes as if it were one level lower. A thread with too many outstanding cache misses is inhibited from decoding. A thread stuck behind a long-latency operation is also inhibited, and when that condition starts it gets a one-cycle flush request for its instructions that are waiting for dispatch. Cycles that a parked or inhibited thread cannot use go to its sibling. In single-thread mode thread 0 takes every decode cycle. All outputs are plain registered control signals and carry no handshake.

Top module: `smt_decode_arb`

## Requirements
- R1: Equal, running, uninhibited priorities make the grant alternate every cycle, so each thread gets 64 of any 128 consecutive cycles. At most one bit of `dec_grant` is high in any cycle. Bit 0 is thread 0 and bit 1 is thread 1.
- R2: When both threads are running and uninhibited and the effective priorities differ by d > 0, the higher thread gets 2^(d+1)-1 of every 2^(d+1) cycles and the lower thread gets the rest. Over 128 cycles this gives 96/32 for d=1, 120/8 for d=3 and 127/1 for d=6. No cycle is left ungranted.
- R3: A thread at priority 0 is never granted. Its sibling, if it is running and uninhibited, is granted every cycle. If both threads are at 0, no grant is issued.
- R4: While `st_mode` is 1, thread 1 is never granted and thread 0, if it is running and uninhibited, is granted every cycle, whatever the priorities are.
- R5: When both raw priorities are 1 and `st_mode` is 0, `pwr_save` is 1 and exactly 4 grants occur in 128 cycles (PSAVE_PERIOD=32), two for each thread. If either priority is not 1, `pwr_save` is 0.
- R6: A thread whose occupancy count is strictly greater than `occ_limit` competes one level lower, but never lower than 1. An occupancy equal to the limit causes no demotion.
- R7: A thread whose miss count is strictly greater than `miss_limit` has its `dec_inhibit` bit at 1 and receives no grant, and its sibling takes every cycle. A miss count equal to the limit does not inhibit.
- R8: A rising long-latency flag raises that thread's `disp_flush` bit for exactly one cycle. `dec_inhibit` stays high while the flag is held and drops one cycle after the flag falls.
- R9: Every output reflects the inputs sampled at the previous rising clock edge, a latency of one cycle. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_mode | input | 1 | Single-thread mode; thread 0 is the active thread |
| t0_prio | input | 3 | Thread 0 priority (0 = parked, 1..7 running) |
| t1_prio | input | 3 | Thread 1 priority |
| t0_occ | input | OCC_W | Thread 0 completion-table occupancy |
| t1_occ | input | OCC_W | Thread 1 completion-table occupancy |
| occ_limit | input | OCC_W | Occupancy threshold for demotion |
| t0_miss | input | MISS_W | Thread 0 outstanding cache misses |
| t1_miss | input | MISS_W | Thread 1 outstanding cache misses |
| miss_limit | input | MISS_W | Miss threshold for inhibit |
| t0_long_op | input | 1 | Thread 0 is blocked by a long-latency operation |
| t1_long_op | input | 1 | Thread 1 is blocked by a long-latency operation |
| dec_grant | output | 2 | Decode grant for this cycle, one bit per thread |
| dec_inhibit | output | 2 | Per-thread decode inhibit |
| disp_flush | output | 2 | Per-thread dispatch flush request pulse |
| pwr_save | output | 1 | Power-saving cadence active |

## Verification
Every result is registered once, so a change applied at a falling edge is visible at the next falling edge, one rising edge later. The latency test samples there. The share tests let two rising edges pass after each input change and then count grants over 128 consecutive falling-edge samples. 128 is the period of the slot pattern, so the counts do not depend on where the window starts. The flush pulse is sampled on the first and second falling edges after the long-latency flag rises, and the inhibit release is sampled one edge after the flag falls.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int PRIO_W   = 3;
  localparam int LEVELS   = 1 << PRIO_W;
  localparam int MAX_DIFF = LEVELS - 2;      // largest gap between two running levels
  localparam int WIN_W    = MAX_DIFF + 1;    // bits needed for the widest share window
  localparam int NTHR     = 2;

  typedef logic [PRIO_W-1:0] prio_t;

  localparam prio_t PRIO_OFF = prio_t'(0);
  localparam prio_t PRIO_LOW = prio_t'(1);
endpackage

// File: rtl/smt_cong_mon.sv
module smt_cong_mon
  import smt_arb_pkg::*;
#(
  parameter int OCC_W  = 6,
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prio_t             prio,
  input  logic [OCC_W-1:0]  occ,
  input  logic [OCC_W-1:0]  occ_lim,
  input  logic [MISS_W-1:0] miss,
  input  logic [MISS_W-1:0] miss_lim,
  input  logic              long_op,
  output prio_t             eff_prio,
  output logic              blk_now,
  output logic              inhibit_q,
  output logic              flush_q
);
  logic demote;
  logic long_d;

  // R6: demotion by one level, floored at the lowest running level
  always_comb begin
    demote   = (occ > occ_lim);
    eff_prio = prio;
    if (demote && (prio > PRIO_LOW)) eff_prio = prio - PRIO_LOW;
    // R7 / R8: blocking conditions
    blk_now  = (miss > miss_lim) || long_op;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_d    <= 1'b0;
      inhibit_q <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      long_d    <= long_op;
      inhibit_q <= blk_now;
      flush_q   <= long_op & ~long_d;
    end
  end
endmodule

// File: rtl/smt_slot_sched.sv
module smt_slot_sched
  import smt_arb_pkg::*;
#(
  parameter int PSAVE_PERIOD = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_mode,
  input  prio_t [NTHR-1:0] raw_prio,
  input  prio_t [NTHR-1:0] eff_prio,
  input  logic  [NTHR-1:0] blk,
  output logic  [NTHR-1:0] grant_q,
  output logic             psave_q
);
  localparam int PS_W   = $clog2(PSAVE_PERIOD);
  localparam int SLOT_W = (WIN_W > PS_W + 1) ? WIN_W : PS_W + 1;

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] mask;
  logic [NTHR-1:0]   elig;
  logic [NTHR-1:0]   gnt_nxt;
  logic              psave_now;
  logic              hi;
  logic              pref;
  prio_t             gap;

  always_comb begin
    elig[0]   = (raw_prio[0] != PRIO_OFF) && !blk[0];
    elig[1]   = (raw_prio[1] != PRIO_OFF) && !blk[1] && !st_mode;   // R4
    psave_now = !st_mode && (raw_prio[0] == PRIO_LOW) && (raw_prio[1] == PRIO_LOW);
    hi        = (eff_prio[1] > eff_prio[0]);
    gap       = hi ? (eff_prio[1] - eff_prio[0]) : (eff_prio[0] - eff_prio[1]);
    mask      = (SLOT_W'(1) << (32'(gap) + 1)) - SLOT_W'(1);
    pref      = slot[PS_W];
    gnt_nxt   = '0;
    if (psave_now) begin
      // R5: one grant per period, alternating preference
      if (slot[PS_W-1:0] == '0) begin
        if (elig[pref])       gnt_nxt[pref]  = 1'b1;
        else if (elig[!pref]) gnt_nxt[!pref] = 1'b1;
      end
    end else if (elig == 2'b11) begin
      if (gap == PRIO_OFF)             gnt_nxt[slot[0]] = 1'b1;  // R1
      else if ((slot & mask) == mask)  gnt_nxt[!hi]     = 1'b1;  // R2
      else                             gnt_nxt[hi]      = 1'b1;
    end else begin
      gnt_nxt = elig;                                            // R3
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot    <= '0;
      grant_q <= '0;
      psave_q <= 1'b0;
    end else begin
      slot    <= slot + SLOT_W'(1);
      grant_q <= gnt_nxt;
      psave_q <= psave_now;
    end
  end
endmodule

// File: rtl/smt_decode_arb.sv
module smt_decode_arb
  import smt_arb_pkg::*;
#(
  parameter int OCC_W        = 6,
  parameter int MISS_W       = 4,
  parameter int PSAVE_PERIOD = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_mode,
  input  logic [2:0]        t0_prio,
  input  logic [2:0]        t1_prio,
  input  logic [OCC_W-1:0]  t0_occ,
  input  logic [OCC_W-1:0]  t1_occ,
  input  logic [OCC_W-1:0]  occ_limit,
  input  logic [MISS_W-1:0] t0_miss,
  input  logic [MISS_W-1:0] t1_miss,
  input  logic [MISS_W-1:0] miss_limit,
  input  logic              t0_long_op,
  input  logic              t1_long_op,
  output logic [1:0]        dec_grant,
  output logic [1:0]        dec_inhibit,
  output logic [1:0]        disp_flush,
  output logic              pwr_save
);
  prio_t [NTHR-1:0]  raw_prio;
  prio_t [NTHR-1:0]  eff_prio;
  logic  [NTHR-1:0]  blk_now;
  logic  [OCC_W-1:0]  occ_a  [NTHR];
  logic  [MISS_W-1:0] miss_a [NTHR];
  logic  [NTHR-1:0]  long_a;

  assign raw_prio[0] = t0_prio;
  assign raw_prio[1] = t1_prio;
  assign occ_a[0]    = t0_occ;
  assign occ_a[1]    = t1_occ;
  assign miss_a[0]   = t0_miss;
  assign miss_a[1]   = t1_miss;
  assign long_a      = {t1_long_op, t0_long_op};

  for (genvar i = 0; i < NTHR; i++) begin : g_mon
    smt_cong_mon #(.OCC_W(OCC_W), .MISS_W(MISS_W)) mon_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .prio     (raw_prio[i]),
      .occ      (occ_a[i]),
      .occ_lim  (occ_limit),
      .miss     (miss_a[i]),
      .miss_lim (miss_limit),
      .long_op  (long_a[i]),
      .eff_prio (eff_prio[i]),
      .blk_now  (blk_now[i]),
      .inhibit_q(dec_inhibit[i]),
      .flush_q  (disp_flush[i])
    );
  end

  smt_slot_sched #(.PSAVE_PERIOD(PSAVE_PERIOD)) sched_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_mode (st_mode),
    .raw_prio(raw_prio),
    .eff_prio(eff_prio),
    .blk     (blk_now),
    .grant_q (dec_grant),
    .psave_q (pwr_save)
  );
endmodule

// File: rtl/smt_decode_arb_chk.sv
module smt_decode_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       st_mode,
  input logic [2:0] t0_prio,
  input logic [2:0] t1_prio,
  input logic [1:0] dec_grant,
  input logic [1:0] dec_inhibit,
  input logic [1:0] disp_flush
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_grant)); // R1
  AST_PARKED_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(t0_prio) == 3'd0) |-> !dec_grant[0]); // R3
  AST_PARKED_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(t1_prio) == 3'd0) |-> !dec_grant[1]); // R3
  AST_ST_T1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_mode) |-> !dec_grant[1]); // R4
  AST_INHIBIT_T0: assert property (@(posedge clk) disable iff (!rst_n)
    dec_inhibit[0] |-> !dec_grant[0]); // R7
  AST_INHIBIT_T1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_inhibit[1] |-> !dec_grant[1]); // R7
  AST_FLUSH_PULSE_T0: assert property (@(posedge clk) disable iff (!rst_n)
    disp_flush[0] |=> !disp_flush[0]); // R8
  AST_FLUSH_PULSE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_flush[1] |=> !disp_flush[1]); // R8
  AST_FLUSH_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_flush & ~dec_inhibit) == 2'b00)); // R8
endmodule

bind smt_decode_arb smt_decode_arb_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_mode    (st_mode),
  .t0_prio    (t0_prio),
  .t1_prio    (t1_prio),
  .dec_grant  (dec_grant),
  .dec_inhibit(dec_inhibit),
  .disp_flush (disp_flush)
);

// File: tb/smt_decode_arb_tb.sv
module smt_decode_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_mode = 1'b0;
  logic [2:0] t0_prio = 3'd0, t1_prio = 3'd0;
  logic [5:0] t0_occ = '0, t1_occ = '0, occ_limit = 6'd20;
  logic [3:0] t0_miss = '0, t1_miss = '0, miss_limit = 4'd6;
  logic       t0_long_op = 1'b0, t1_long_op = 1'b0;
  logic [1:0] dec_grant, dec_inhibit, disp_flush;
  logic       pwr_save;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  smt_decode_arb dut_i (
    .clk(clk), .rst_n(rst_n), .st_mode(st_mode),
    .t0_prio(t0_prio), .t1_prio(t1_prio),
    .t0_occ(t0_occ), .t1_occ(t1_occ), .occ_limit(occ_limit),
    .t0_miss(t0_miss), .t1_miss(t1_miss), .miss_limit(miss_limit),
    .t0_long_op(t0_long_op), .t1_long_op(t1_long_op),
    .dec_grant(dec_grant), .dec_inhibit(dec_inhibit),
    .disp_flush(disp_flush), .pwr_save(pwr_save)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // counts over one 128-cycle window
  task automatic window(output int c0, output int c1, output int idle, output int repeats);
    logic [1:0] prev;
    c0 = 0; c1 = 0; idle = 0; repeats = 0; prev = 2'b00;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (dec_grant[0]) c0++;
      if (dec_grant[1]) c1++;
      if (dec_grant == 2'b00) idle++;
      if (dec_grant != 2'b00 && dec_grant == prev) repeats++;
      prev = dec_grant;
    end
  endtask

  task automatic setp(input logic [2:0] p0, input logic [2:0] p1);
    @(negedge clk);
    t0_prio = p0; t1_prio = p1;
    settle();
  endtask

  task automatic t_reset();
    chk("R9 reset grant", dec_grant, 0);
    chk("R9 reset inhibit", dec_inhibit, 0);
    chk("R9 reset flush", disp_flush, 0);
    chk("R9 reset pwr_save", pwr_save, 0);
  endtask

  task automatic t_equal();
    int c0, c1, id, rp;
    setp(3'd4, 3'd4);
    window(c0, c1, id, rp);
    chk("R1 equal t0 share", c0, 64);
    chk("R1 equal t1 share", c1, 64);
    chk("R1 alternation repeats", rp, 0);
  endtask

  task automatic t_share();
    int c0, c1, id, rp;
    setp(3'd5, 3'd4);
    window(c0, c1, id, rp);
    chk("R2 d=1 high share", c0, 96);
    chk("R2 d=1 low share", c1, 32);
    setp(3'd2, 3'd5);
    window(c0, c1, id, rp);
    chk("R2 d=3 high share", c1, 120);
    chk("R2 d=3 idle", id, 0);
    setp(3'd7, 3'd1);
    window(c0, c1, id, rp);
    chk("R2 d=6 high share", c0, 127);
    chk("R2 d=6 low share", c1, 1);
  endtask

  task automatic t_parked();
    int c0, c1, id, rp;
    setp(3'd0, 3'd3);
    window(c0, c1, id, rp);
    chk("R3 parked t0 grants", c0, 0);
    chk("R3 sibling all cycles", c1, 128);
    setp(3'd0, 3'd0);
    window(c0, c1, id, rp);
    chk("R3 both parked idle", id, 128);
  endtask

  task automatic t_single();
    int c0, c1, id, rp;
    @(negedge clk);
    st_mode = 1'b1; t0_prio = 3'd2; t1_prio = 3'd7;
    settle();
    window(c0, c1, id, rp);
    chk("R4 st t0 all", c0, 128);
    chk("R4 st t1 none", c1, 0);
    @(negedge clk);
    st_mode = 1'b0;
  endtask

  task automatic t_psave();
    int c0, c1, id, rp;
    setp(3'd1, 3'd1);
    chk("R5 pwr_save on", pwr_save, 1);
    window(c0, c1, id, rp);
    chk("R5 psave t0 grants", c0, 2);
    chk("R5 psave t1 grants", c1, 2);
    setp(3'd1, 3'd2);
    chk("R5 pwr_save off", pwr_save, 0);
    window(c0, c1, id, rp);
    chk("R5 no psave high share", c1, 96);
  endtask

  task automatic t_occ();
    int c0, c1, id, rp;
    @(negedge clk);
    t0_prio = 3'd4; t1_prio = 3'd3; t0_occ = 6'd21;
    settle();
    window(c0, c1, id, rp);
    chk("R6 demoted equal share", c0, 64);
    @(negedge clk);
    t0_occ = 6'd20;
    settle();
    window(c0, c1, id, rp);
    chk("R6 at limit no demote", c0, 96);
    @(negedge clk);
    t0_prio = 3'd1; t1_prio = 3'd0; t0_occ = 6'd40;
    settle();
    window(c0, c1, id, rp);
    chk("R6 floor stays running", c0, 128);
    @(negedge clk);
    t0_occ = '0;
  endtask

  task automatic t_miss();
    int c0, c1, id, rp;
    @(negedge clk);
    t0_prio = 3'd6; t1_prio = 3'd2; t0_miss = 4'd7;
    settle();
    chk("R7 inhibit set", dec_inhibit, 1);
    window(c0, c1, id, rp);
    chk("R7 inhibited no grants", c0, 0);
    chk("R7 sibling all", c1, 128);
    @(negedge clk);
    t0_miss = 4'd6;
    settle();
    chk("R7 at limit no inhibit", dec_inhibit, 0);
    @(negedge clk);
    t0_miss = '0;
  endtask

  task automatic t_long();
    @(negedge clk);
    t0_prio = 3'd3; t1_prio = 3'd3; t1_long_op = 1'b1;
    @(negedge clk);
    chk("R8 flush pulse", disp_flush, 2);
    chk("R8 inhibit with flush", dec_inhibit, 2);
    @(negedge clk);
    chk("R8 flush single cycle", disp_flush, 0);
    chk("R8 held inhibited grant", dec_grant, 1);
    repeat (5) @(negedge clk);
    chk("R8 inhibit held", dec_inhibit, 2);
    t1_long_op = 1'b0;
    @(negedge clk);
    chk("R8 inhibit released", dec_inhibit, 0);
  endtask

  task automatic t_latency();
    setp(3'd3, 3'd0);
    chk("R9 steady t0", dec_grant, 1);
    t0_prio = 3'd0; t1_prio = 3'd3;
    @(negedge clk);
    chk("R9 one-cycle switch", dec_grant, 2);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_equal();
    t_share();
    t_parked();
    t_single();
    t_psave();
    t_occ();
    t_miss();
    t_long();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule